// File: doc/BRIEF.md
# Three-Phase Voltage Sag Status Monitor

This block watches signed voltage samples for three phases, A, B and C. One set of samples arrives with each pulse of a sample strobe. For each phase it keeps a sticky sag flag. A flag sets only after that phase's magnitude has stayed below a programmable threshold for a programmed number of consecutive samples. A single sample at or above the threshold clears the flag.

From phase A it also derives a square wave at the line fundamental. The wave toggles on each positive-going zero crossing, and a small hysteresis band around zero suppresses noise.

The flags and the square wave are packed into a 32-bit status word. The word is registered once per sample pass, together with a one-cycle end-of-pass interrupt pulse, so that an interrupt handler can read all early power-fail information with a single access. The threshold and the count come in as configuration inputs.

Top module: `sag_status_mon`

## Requirements
- R1: Status bit 0 is the sag flag of phase A, bit 1 is the flag of phase B and bit 2 is the flag of phase C.
- R2: Status bits 31 down to 4 always read as zero.
- R3: A phase flag becomes 1 only after `cfg_cnt` consecutive strobed samples whose magnitude is strictly below `cfg_thr`. It does not set after fewer such samples.
- R4: One strobed sample with magnitude at or above `cfg_thr` clears that phase's flag and restarts its count from zero.
- R5: A `cfg_cnt` of 0 behaves as 1, so a single below-threshold sample sets the flag.
- R6: The status word is loaded one clock after the clock edge that captures the strobe. `irq_pass` is high for exactly that one cycle.
- R7: With no strobe, the status word holds its value and `irq_pass` stays low, whatever the sample inputs do.
- R8: Status bit 3 toggles when a phase A sample above +HYST (default 8) follows an earlier phase A sample below -HYST. Samples inside the band neither arm nor toggle the wave.
- R9: Synchronous reset clears the counters, the flags, the square wave, the status word and `irq_pass`.
- R10: Samples are compared by magnitude, so negative samples (including the most negative code) qualify the same way as positive samples of equal size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe, one cycle per pass |
| smp_a | input | SMP_W | Phase A signed sample |
| smp_b | input | SMP_W | Phase B signed sample |
| smp_c | input | SMP_W | Phase C signed sample |
| cfg_thr | input | SMP_W | Unsigned sag threshold on sample magnitude |
| cfg_cnt | input | CNT_W | Consecutive below-threshold samples needed to set a flag |
| stat_word | output | STAT_W | Packed status word |
| irq_pass | output | 1 | End-of-pass interrupt pulse |

## Verification
A strobe captured at clock edge k updates the flags and the square wave at edge k. Both then appear in `stat_word`, together with `irq_pass`, after edge k+1. The bench drives each strobe at a falling edge and removes it at the next falling edge. It then waits one more falling edge, so that the sample lands after edge k+1, and reads the word and the interrupt there. It reads `irq_pass` again one cycle later to confirm the pulse has ended. The hold checks change the inputs without a strobe and read the word several cycles later.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum int unsigned {PH_A = 0, PH_B = 1, PH_C = 2} phase_e;
  localparam int unsigned N_PHASE = 3;
  localparam int unsigned SQ_BIT  = 3;
endpackage

// File: rtl/sag_phase_qual.sv
module sag_phase_qual #(
  parameter int SMP_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] thr,
  input  logic [CNT_W-1:0] cnt_lim,
  output logic             flag
);
  logic [SMP_W-1:0] mag;
  logic             below;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             flag_q;

  always_comb begin
    mag     = smp[SMP_W-1] ? (~smp + SMP_W'(1)) : smp;
    below   = (mag < thr);
    lim     = (cnt_lim == '0) ? CNT_W'(1) : cnt_lim;
    cnt_nxt = (cnt_q >= lim) ? cnt_q : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (smp_vld) begin
      if (below) begin
        cnt_q  <= cnt_nxt;
        flag_q <= flag_q | (cnt_nxt >= lim);
      end else begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/sag_freq_sq.sv
module sag_freq_sq #(
  parameter int SMP_W = 16,
  parameter int HYST  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp,
  output logic             sq
);
  localparam logic signed [SMP_W-1:0] HI_LIM = SMP_W'(HYST);
  localparam logic signed [SMP_W-1:0] LO_LIM = -HI_LIM;

  logic arm_q;
  logic sq_q;
  logic is_hi;
  logic is_lo;

  always_comb begin
    is_hi = $signed(smp) > HI_LIM;
    is_lo = $signed(smp) < LO_LIM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
      sq_q  <= 1'b0;
    end else if (smp_vld) begin
      if (is_lo) begin
        arm_q <= 1'b1;
      end else if (is_hi && arm_q) begin
        arm_q <= 1'b0;
        sq_q  <= ~sq_q;
      end
    end
  end

  assign sq = sq_q;
endmodule

// File: rtl/sag_stat_reg.sv
module sag_stat_reg #(
  parameter int STAT_W = 32,
  parameter int NPH    = 3,
  parameter int SQ_POS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [NPH-1:0]    flags,
  input  logic              sq,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic              vld_d;
  logic [STAT_W-1:0] word;
  logic [STAT_W-1:0] stat_q;
  logic              irq_q;

  always_comb begin
    word             = '0;
    word[NPH-1:0]    = flags;
    word[SQ_POS]     = sq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_d  <= 1'b0;
      irq_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      vld_d <= smp_vld;
      irq_q <= vld_d;
      if (vld_d) stat_q <= word;
    end
  end

  assign stat = stat_q;
  assign irq  = irq_q;
endmodule

// File: rtl/sag_status_mon.sv
module sag_status_mon
  import sag_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int CNT_W  = 8,
  parameter int STAT_W = 32,
  parameter int HYST   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic [SMP_W-1:0]  smp_b,
  input  logic [SMP_W-1:0]  smp_c,
  input  logic [SMP_W-1:0]  cfg_thr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  output logic [STAT_W-1:0] stat_word,
  output logic              irq_pass
);
  localparam int NPH = int'(N_PHASE);

  logic [SMP_W-1:0] smp_arr [NPH];
  logic [NPH-1:0]   flags;
  logic             sq;

  always_comb begin
    smp_arr[PH_A] = smp_a;
    smp_arr[PH_B] = smp_b;
    smp_arr[PH_C] = smp_c;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    sag_phase_qual #(.SMP_W(SMP_W), .CNT_W(CNT_W)) qual_i (
      .clk     (clk),
      .rst     (rst),
      .smp_vld (smp_vld),
      .smp     (smp_arr[p]),
      .thr     (cfg_thr),
      .cnt_lim (cfg_cnt),
      .flag    (flags[p])
    );
  end

  sag_freq_sq #(.SMP_W(SMP_W), .HYST(HYST)) freq_i (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .smp     (smp_a),
    .sq      (sq)
  );

  sag_stat_reg #(.STAT_W(STAT_W), .NPH(NPH), .SQ_POS(int'(SQ_BIT))) stat_i (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .flags   (flags),
    .sq      (sq),
    .stat    (stat_word),
    .irq     (irq_pass)
  );
endmodule

// File: rtl/sag_status_mon_chk.sv
module sag_status_mon_chk #(
  parameter int SMP_W  = 16,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_vld,
  input logic [SMP_W-1:0]  smp_a,
  input logic [SMP_W-1:0]  cfg_thr,
  input logic [STAT_W-1:0] stat_word,
  input logic              irq_pass
);
  logic [SMP_W-1:0] mag_a;
  assign mag_a = smp_a[SMP_W-1] ? (~smp_a + SMP_W'(1)) : smp_a;

  a_r6_irq_after_strobe: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> ##1 irq_pass);

  a_r6_irq_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    irq_pass |-> $past(smp_vld, 2));

  a_r7_hold_without_irq: assert property (@(posedge clk) disable iff (rst)
    !irq_pass |-> $stable(stat_word));

  a_r4_clear_on_high: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && (mag_a >= cfg_thr)) |=> ##1 !stat_word[0]);

  a_r1_rise_with_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_word[0]) |-> irq_pass);
endmodule

bind sag_status_mon sag_status_mon_chk #(.SMP_W(SMP_W), .STAT_W(STAT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .smp_vld   (smp_vld),
  .smp_a     (smp_a),
  .cfg_thr   (cfg_thr),
  .stat_word (stat_word),
  .irq_pass  (irq_pass)
);

// File: tb/sag_status_mon_tb_top.sv
module sag_status_mon_tb_top;
  localparam int SMP_W = 16;
  localparam int CNT_W = 8;
  localparam int STAT_W = 32;
  localparam int NVEC = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_vld = 1'b0;
  logic [SMP_W-1:0]  smp_a = '0, smp_b = '0, smp_c = '0;
  logic [SMP_W-1:0]  cfg_thr = 16'd100;
  logic [CNT_W-1:0]  cfg_cnt = 8'd3;
  logic [STAT_W-1:0] stat_word;
  logic              irq_pass;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sag_status_mon dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .smp_a(smp_a), .smp_b(smp_b), .smp_c(smp_c),
    .cfg_thr(cfg_thr), .cfg_cnt(cfg_cnt),
    .stat_word(stat_word), .irq_pass(irq_pass)
  );

  // {a, b, c, expected status bits 3..0}; threshold 100, count 3, hysteresis 8
  localparam logic [51:0] VEC [NVEC] = '{
    {16'sd500,    16'sd500,    16'sd500, 4'h0},
    {-16'sd500,   16'sd50,     16'sd500, 4'h0},
    {-16'sd50,    -16'sd50,    16'sd500, 4'h0},
    {16'sd20,     16'sd0,      16'sd10,  4'hA},
    {-16'sd20,    16'sd99,     -16'sd99, 4'hB},
    {16'sd100,    -16'sd100,   16'sd5,   4'h4},
    {16'h8000,    16'h8000,    16'sd0,   4'h4},
    {16'sd3,      16'sd0,      16'sd200, 4'h0},
    {16'sd9,      16'sd0,      16'sd0,   4'h8},
    {16'sd50,     16'sd0,      16'sd0,   4'hB},
    {16'sd50,     16'sd100,    16'sd0,   4'hD},
    {-16'sd10,    -16'sd10,    -16'sd10, 4'hD}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Strobe one sample set; return after the status register has loaded.
  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    @(negedge clk);
    smp_a = a; smp_b = b; smp_c = c; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset stat", stat_word, 32'h0);
    check("R9 reset irq", {31'b0, irq_pass}, 32'h0);

    // R1 R2 R3 R4 R8 R10 via vector walk
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][51:36], VEC[i][35:20], VEC[i][19:4]);
      check("R6 irq pulse", {31'b0, irq_pass}, 32'h1);
      check("R1 R2 R3 R4 R8 R10 status", stat_word, {28'b0, VEC[i][3:0]});
      @(negedge clk);
      check("R6 irq one cycle", {31'b0, irq_pass}, 32'h0);
    end

    // R7: inputs move without strobe, word holds
    smp_a = 16'sd1000; smp_b = 16'sd1000; smp_c = 16'sd1000;
    repeat (5) @(negedge clk);
    check("R7 hold stat", stat_word, 32'hD);
    check("R7 no irq", {31'b0, irq_pass}, 32'h0);

    // R9: reset with flags set
    do_reset();
    @(negedge clk);
    check("R9 mid-run reset", stat_word, 32'h0);

    // R5: count 0 behaves as 1
    cfg_cnt = 8'd0;
    send(16'sd0, 16'sd500, 16'sd500);
    check("R5 zero count", stat_word, 32'h1);

    // R3 boundary: count 5, four samples do not set, fifth does
    cfg_cnt = 8'd5;
    do_reset();
    for (int k = 0; k < 4; k++) send(16'sd500, 16'sd500, -16'sd7);
    check("R3 not before count", stat_word, 32'h0);
    send(16'sd500, 16'sd500, -16'sd7);
    check("R3 set at count", stat_word, 32'h4);

    // R4: single high sample clears and restarts count
    send(16'sd500, 16'sd500, 16'sd100);
    check("R4 clear", stat_word, 32'h0);
    for (int k = 0; k < 4; k++) send(16'sd500, 16'sd500, 16'sd1);
    check("R4 count restarted", stat_word, 32'h0);

    // R8: in-band samples neither arm nor toggle
    do_reset();
    send(-16'sd8, 16'sd500, 16'sd500);
    send(16'sd500, 16'sd500, 16'sd500);
    check("R8 band no arm", stat_word, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule